// File: doc/BRIEF.md
# Secure Backup Register File

A bank of general-purpose retention words behind a simple request/response register bus. Every access carries a secure attribute and a privileged attribute. When the security enable input is high, two programmable boundary indices split the bank into three protection zones. The lowest zone is open only to secure accesses. The middle zone takes only secure writes but allows any read. The top zone is open to everyone. When security is off, every entry is open to any access.

The bank protects its contents in three ways. Software can wipe it with a one-shot erase command. A tamper flag holds the whole bank at zero for as long as it stays set, unless that source has its no-erase bit set. A block bit shuts off all bank traffic while it is set. A denied access never changes state, reads back zero, and raises a one-cycle bus error.

Each request is answered in the following cycle on `rdata_o` and `err_o`. Both outputs are zero in any cycle that does not answer a request.

Top module: `secure_backup_regfile`

## Requirements
- R1: Bank entry i sits at byte address 0x100 + 4*i, for i from 0 to 31. The zone register is at 0x000, with the first boundary in bits [7:0] and the second boundary in bits [23:16]. The control register is at 0x004, with erase in bit 0, block in bit 1 and the per-tamper no-erase mask in bits [15:8]. A request sampled at a clock edge is answered on `rdata_o`/`err_o` after that edge. Both outputs are 0 in any cycle that does not answer a request.
- R2: With `sec_en_i` low, every bank entry is readable and writable by non-secure accesses.
- R3: With `sec_en_i` high, entries with index below the first boundary accept only secure reads and writes.
- R4: With `sec_en_i` high, entries from the first boundary up to the second boundary minus 1 accept any read but only secure writes.
- R5: Entries at or above the second boundary accept any access. A first boundary of 0 leaves no secure-only zone. A second boundary at or below the first leaves no write-protected zone.
- R6: A denied access returns zero read data, leaves all state unchanged and sets `err_o` for exactly the answering cycle.
- R7: While `lock_rw_i` is set, the first boundary field changes only on privileged writes. While `lock_w_i` is set, the same holds for the second boundary field. A non-privileged write to the zone register while either lock is set raises `err_o`. Fields that are not locked still take the written value.
- R8: Writing 1 to the erase bit clears every bank entry in the same cycle. The erase bit always reads back as 0.
- R9: While any bit of `tamper_i` is set whose no-erase bit is clear, all entries are held at zero. Reads return 0 and bank writes are dropped without an error. Contents are not restored when the flag drops. A tamper source with its no-erase bit set has no effect on the bank.
- R10: While the block bit is set, every bank read and write is denied, including secure ones. The zone and control registers stay accessible.
- R11: An access to an address outside the bank and the two configuration registers, or to an address that is not word-aligned, is denied.
- R12: After reset, all entries, both boundaries, the block bit, the no-erase mask and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| sec_i | input | 1 | Access is secure |
| priv_i | input | 1 | Access is privileged |
| sec_en_i | input | 1 | Enables zone protection |
| lock_rw_i | input | 1 | First boundary writable only by privileged accesses |
| lock_w_i | input | 1 | Second boundary writable only by privileged accesses |
| tamper_i | input | 8 | Tamper flags, one per source |
| rdata_o | output | 32 | Read data, answering cycle |
| err_o | output | 1 | Denied access, answering cycle |

## Verification
The bench probes the indices on either side of each boundary: the last secure-only entry, the first and last write-protected entries, and the first open entry. A design with an off-by-one compare would let a non-secure access into a protected entry, or would reject a legal one. The degenerate settings, a zero first boundary and an inverted pair, catch a decoder that builds a zone out of an empty range. Denied writes are followed by secure read-back, which exposes a design that drops the error but still stores the data. The tamper tests cover the no-erase mask, a mix of erasing and non-erasing sources, and read-back after the flag drops. A design that only masks read data, instead of clearing the contents, would return the old value there.

// File: rtl/bkp_pkg.sv
`timescale 1ns/1ps
package bkp_pkg;
  typedef enum logic [1:0] {
    ZN_SEC_RW = 2'd0,  // secure read and write only
    ZN_SEC_WR = 2'd1,  // secure write, any read
    ZN_OPEN   = 2'd2
  } zone_e;
endpackage

// File: rtl/bkp_zone_decode.sv
`timescale 1ns/1ps
module bkp_zone_decode
  import bkp_pkg::*;
#(
  parameter int unsigned IDXW = 5,
  parameter int unsigned BW   = 8
) (
  input  logic [IDXW-1:0] idx_i,
  input  logic [BW-1:0]   bnd_rw_i,
  input  logic [BW-1:0]   bnd_w_i,
  output zone_e           zone_o
);
  logic [BW-1:0] idx_ext;
  assign idx_ext = BW'(idx_i);

  // an inverted boundary pair falls through to ZN_OPEN: no middle zone
  always_comb begin
    if (idx_ext < bnd_rw_i)     zone_o = ZN_SEC_RW;
    else if (idx_ext < bnd_w_i) zone_o = ZN_SEC_WR;
    else                        zone_o = ZN_OPEN;
  end
endmodule

// File: rtl/bkp_access_ctrl.sv
`timescale 1ns/1ps
module bkp_access_ctrl
  import bkp_pkg::*;
(
  input  zone_e zone_i,
  input  logic  sec_en_i,
  input  logic  sec_i,
  input  logic  we_i,
  input  logic  block_i,
  output logic  allow_o
);
  always_comb begin
    if (block_i)       allow_o = 1'b0;
    else if (!sec_en_i) allow_o = 1'b1;
    else begin
      unique case (zone_i)
        ZN_SEC_RW: allow_o = sec_i;
        ZN_SEC_WR: allow_o = sec_i | ~we_i;
        default:   allow_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bkp_cfg_regs.sv
`timescale 1ns/1ps
module bkp_cfg_regs #(
  parameter int unsigned BW    = 8,
  parameter int unsigned NTAMP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zone_we_i,
  input  logic             ctrl_we_i,
  input  logic             priv_i,
  input  logic             lock_rw_i,
  input  logic             lock_w_i,
  input  logic [BW-1:0]    bnd_rw_d_i,
  input  logic [BW-1:0]    bnd_w_d_i,
  input  logic             erase_d_i,
  input  logic             block_d_i,
  input  logic [NTAMP-1:0] noerase_d_i,
  output logic [BW-1:0]    bnd_rw_o,
  output logic [BW-1:0]    bnd_w_o,
  output logic             block_o,
  output logic [NTAMP-1:0] noerase_o,
  output logic             erase_o,
  output logic             lock_err_o
);
  logic rw_ok, w_ok;
  assign rw_ok = ~lock_rw_i | priv_i;
  assign w_ok  = ~lock_w_i | priv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bnd_rw_o <= '0;
      bnd_w_o  <= '0;
    end else if (zone_we_i) begin
      if (rw_ok) bnd_rw_o <= bnd_rw_d_i;
      if (w_ok)  bnd_w_o  <= bnd_w_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      block_o   <= 1'b0;
      noerase_o <= '0;
    end else if (ctrl_we_i) begin
      block_o   <= block_d_i;
      noerase_o <= noerase_d_i;
    end
  end

  // erase is a strobe, never stored
  assign erase_o    = ctrl_we_i & erase_d_i;
  assign lock_err_o = zone_we_i & ~(rw_ok & w_ok);
endmodule

// File: rtl/bkp_bank.sv
`timescale 1ns/1ps
module bkp_bank #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned IDXW     = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            we_i,
  input  logic [IDXW-1:0] widx_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   mem_o [NUM_REGS]
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (clr_i)                             q <= '0;  // clear beats write
      else if (we_i && widx_i == IDXW'(g))        q <= wdata_i;
    end
    assign mem_o[g] = q;
  end
endmodule

// File: rtl/secure_backup_regfile.sv
`timescale 1ns/1ps
module secure_backup_regfile
  import bkp_pkg::*;
#(
  parameter int unsigned   NUM_REGS  = 32,
  parameter int unsigned   DW        = 32,
  parameter int unsigned   AW        = 12,
  parameter int unsigned   BW        = 8,
  parameter int unsigned   NTAMP     = 8,
  parameter logic [AW-1:0] BANK_BASE = 12'h100,
  parameter logic [AW-1:0] ZONE_ADDR = 12'h000,
  parameter logic [AW-1:0] CTRL_ADDR = 12'h004
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             sec_i,
  input  logic             priv_i,
  input  logic             sec_en_i,
  input  logic             lock_rw_i,
  input  logic             lock_w_i,
  input  logic [NTAMP-1:0] tamper_i,
  output logic [DW-1:0]    rdata_o,
  output logic             err_o
);
  localparam int unsigned   IDXW      = $clog2(NUM_REGS);
  localparam logic [AW-1:0] BANK_LAST = BANK_BASE + AW'(4 * (NUM_REGS - 1));
  localparam int unsigned   W2_LSB    = 16;
  localparam int unsigned   NE_LSB    = 8;

  logic            aligned, hit_bank, hit_zone, hit_ctrl, miss;
  logic [IDXW-1:0] bank_idx;
  logic [BW-1:0]   bnd_rw, bnd_w;
  logic            block_q, erase_stb, lock_err, allow, hold, bank_clr, bank_we;
  logic [NTAMP-1:0] noerase_q;
  logic [DW-1:0]   mem [NUM_REGS];
  zone_e           zone;
  logic [DW-1:0]   rdata_d;
  logic            err_d;

  // decode
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign hit_bank = aligned && addr_i >= BANK_BASE && addr_i <= BANK_LAST;
  assign hit_zone = (addr_i == ZONE_ADDR);
  assign hit_ctrl = (addr_i == CTRL_ADDR);
  assign miss     = req_i & ~(hit_bank | hit_zone | hit_ctrl);
  assign bank_idx = addr_i[IDXW+1:2];

  bkp_cfg_regs #(.BW(BW), .NTAMP(NTAMP)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .zone_we_i   (req_i & we_i & hit_zone),
    .ctrl_we_i   (req_i & we_i & hit_ctrl),
    .priv_i      (priv_i),
    .lock_rw_i   (lock_rw_i),
    .lock_w_i    (lock_w_i),
    .bnd_rw_d_i  (wdata_i[BW-1:0]),
    .bnd_w_d_i   (wdata_i[W2_LSB +: BW]),
    .erase_d_i   (wdata_i[0]),
    .block_d_i   (wdata_i[1]),
    .noerase_d_i (wdata_i[NE_LSB +: NTAMP]),
    .bnd_rw_o    (bnd_rw),
    .bnd_w_o     (bnd_w),
    .block_o     (block_q),
    .noerase_o   (noerase_q),
    .erase_o     (erase_stb),
    .lock_err_o  (lock_err)
  );

  bkp_zone_decode #(.IDXW(IDXW), .BW(BW)) u_zone (
    .idx_i    (bank_idx),
    .bnd_rw_i (bnd_rw),
    .bnd_w_i  (bnd_w),
    .zone_o   (zone)
  );

  bkp_access_ctrl u_acc (
    .zone_i   (zone),
    .sec_en_i (sec_en_i),
    .sec_i    (sec_i),
    .we_i     (we_i),
    .block_i  (block_q),
    .allow_o  (allow)
  );

  assign hold     = |(tamper_i & ~noerase_q);
  assign bank_clr = hold | erase_stb;
  assign bank_we  = req_i & we_i & hit_bank & allow;

  bkp_bank #(.NUM_REGS(NUM_REGS), .DW(DW), .IDXW(IDXW)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (bank_clr),
    .we_i    (bank_we),
    .widx_i  (bank_idx),
    .wdata_i (wdata_i),
    .mem_o   (mem)
  );

  // response
  always_comb begin
    rdata_d = '0;
    err_d   = miss | (req_i & hit_bank & ~allow) | lock_err;
    if (req_i && !we_i) begin
      if (hit_bank) begin
        if (allow && !hold) rdata_d = mem[bank_idx];
      end else if (hit_zone) begin
        rdata_d[BW-1:0]      = bnd_rw;
        rdata_d[W2_LSB +: BW] = bnd_w;
      end else if (hit_ctrl) begin
        rdata_d[1]                = block_q;
        rdata_d[NE_LSB +: NTAMP]  = noerase_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rdata_d;
      err_o   <= err_d;
    end
  end
endmodule

// File: rtl/bkp_checker.sv
`timescale 1ns/1ps
module bkp_checker #(
  parameter int unsigned DW   = 32,
  parameter int unsigned IDXW = 5,
  parameter int unsigned BW   = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            sec_i,
  input logic            sec_en_i,
  input logic            in_bank,
  input logic [IDXW-1:0] idx,
  input logic [BW-1:0]   bnd_rw,
  input logic            block,
  input logic            hold,
  input logic [DW-1:0]   bank0,
  input logic [DW-1:0]   rdata_o,
  input logic            err_o
);
  AST_DENY_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0); // R6

  AST_ERR_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !err_o && rdata_o == '0); // R1

  AST_ZONE1_NONSEC_DENIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && in_bank && sec_en_i && !sec_i && (BW'(idx) < bnd_rw)) |=> err_o); // R3

  AST_BLOCK_DENIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && in_bank && block) |=> err_o); // R10

  AST_HOLD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> bank0 == '0); // R9
endmodule

bind secure_backup_regfile bkp_checker #(.DW(DW), .IDXW(IDXW), .BW(BW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .sec_i    (sec_i),
  .sec_en_i (sec_en_i),
  .in_bank  (hit_bank),
  .idx      (bank_idx),
  .bnd_rw   (bnd_rw),
  .block    (block_q),
  .hold     (hold),
  .bank0    (mem[0]),
  .rdata_o  (rdata_o),
  .err_o    (err_o)
);

// File: tb/tb_secure_backup_regfile.sv
`timescale 1ns/1ps
module tb_secure_backup_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sec = 1'b0, priv = 1'b0;
  logic        sec_en = 1'b0, lock_rw = 1'b0, lock_w = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  tamper = '0;
  logic [31:0] rdata;
  logic        err;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  secure_backup_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .sec_i(sec), .priv_i(priv), .sec_en_i(sec_en),
    .lock_rw_i(lock_rw), .lock_w_i(lock_w), .tamper_i(tamper),
    .rdata_o(rdata), .err_o(err)
  );

  function automatic logic [11:0] ea(input int i);
    return 12'h100 + 12'(4 * i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic s,
                    input logic p, output logic e);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; sec = s; priv = p;
    @(negedge clk);
    e = err; req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic s, output logic [31:0] d,
                    output logic e);
    @(negedge clk);
    req = 1; we = 0; addr = a; sec = s; priv = 0;
    @(negedge clk);
    d = rdata; e = err; req = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    chk("R12 idle rdata", rdata, 0);
    chk("R12 idle err", 32'(err), 0);
    rd(12'h000, 1, d, e); chk("R12 zone reg", d, 0);
    rd(12'h004, 1, d, e); chk("R12 ctrl reg", d, 0);
    rd(ea(7), 1, d, e);   chk("R12 entry", d, 0); chk("R12 err", 32'(e), 0);
  endtask

  task automatic t_open();
    logic [31:0] d; logic e;
    sec_en = 0;
    wr(12'h000, 32'h0010_0008, 0, 0, e);
    wr(ea(0), 32'hA5A5_0000, 0, 0, e); chk("R2 nonsec wr idx0 err", 32'(e), 0);
    wr(ea(31), 32'h1234_5678, 0, 0, e);
    rd(ea(0), 0, d, e);  chk("R2 nonsec rd idx0", d, 32'hA5A5_0000);
    rd(ea(31), 0, d, e); chk("R2 nonsec rd idx31", d, 32'h1234_5678);
    @(negedge clk); chk("R1 idle after read", rdata, 0);
  endtask

  task automatic t_zones();
    logic [31:0] d; logic e;
    sec_en = 1;
    wr(12'h000, 32'h000A_0004, 0, 0, e); chk("R1 zone wr err", 32'(e), 0);
    rd(12'h000, 0, d, e); chk("R1 zone readback", d, 32'h000A_0004);
    wr(ea(2), 32'h2222, 1, 0, e); chk("R3 sec wr zone1", 32'(e), 0);
    rd(ea(2), 0, d, e); chk("R3 nonsec rd zone1 err", 32'(e), 1); chk("R6 denied rd data", d, 0);
    wr(ea(2), 32'hDEAD, 0, 0, e); chk("R3 nonsec wr zone1 err", 32'(e), 1);
    rd(ea(2), 1, d, e); chk("R6 denied wr dropped", d, 32'h2222);
    rd(ea(3), 0, d, e); chk("R3 last zone1 idx", 32'(e), 1);
    wr(ea(4), 32'h4444, 1, 0, e); chk("R4 sec wr zone2", 32'(e), 0);
    rd(ea(4), 0, d, e); chk("R4 nonsec rd zone2", d, 32'h4444); chk("R4 rd err", 32'(e), 0);
    wr(ea(4), 32'h0BAD, 0, 0, e); chk("R4 nonsec wr zone2 err", 32'(e), 1);
    rd(ea(4), 1, d, e); chk("R4 zone2 unchanged", d, 32'h4444);
    wr(ea(9), 32'h9, 0, 0, e); chk("R4 last zone2 idx", 32'(e), 1);
    wr(ea(10), 32'h1010, 0, 0, e); chk("R5 zone3 wr", 32'(e), 0);
    rd(ea(10), 0, d, e); chk("R5 zone3 rd", d, 32'h1010);
  endtask

  task automatic t_degenerate();
    logic [31:0] d; logic e;
    wr(12'h000, 32'h0000_0000, 0, 0, e);
    wr(ea(0), 32'h0F0F, 0, 0, e); chk("R5 no zone1 wr", 32'(e), 0);
    rd(ea(0), 0, d, e); chk("R5 no zone1 rd", d, 32'h0F0F);
    wr(12'h000, 32'h0003_0006, 0, 0, e);
    rd(ea(4), 0, d, e); chk("R5 inverted, idx4 zone1", 32'(e), 1);
    wr(ea(7), 32'h7777, 0, 0, e); chk("R5 inverted, no zone2", 32'(e), 0);
    rd(ea(7), 0, d, e); chk("R5 idx7 open", d, 32'h7777);
  endtask

  task automatic t_priv();
    logic [31:0] d; logic e;
    lock_rw = 1;
    wr(12'h000, 32'h0005_0002, 0, 0, e); chk("R7 locked nonpriv err", 32'(e), 1);
    rd(12'h000, 0, d, e); chk("R7 only unlocked field moved", d, 32'h0005_0006);
    wr(12'h000, 32'h0005_0002, 0, 1, e); chk("R7 priv wr err", 32'(e), 0);
    rd(12'h000, 0, d, e); chk("R7 priv wr took", d, 32'h0005_0002);
    lock_rw = 0; lock_w = 1;
    wr(12'h000, 32'h000C_0002, 0, 0, e); chk("R7 lock_w nonpriv err", 32'(e), 1);
    rd(12'h000, 0, d, e); chk("R7 second bound kept", d, 32'h0005_0002);
    lock_w = 0;
  endtask

  task automatic t_erase();
    logic [31:0] d; logic e;
    wr(ea(10), 32'hABCD, 1, 0, e);
    wr(12'h004, 32'h0000_0001, 0, 0, e); chk("R8 erase wr err", 32'(e), 0);
    rd(12'h004, 0, d, e); chk("R8 erase bit reads 0", d, 0);
    rd(ea(10), 1, d, e);  chk("R8 idx10 cleared", d, 0);
    rd(ea(31), 1, d, e);  chk("R8 idx31 cleared", d, 0);
  endtask

  task automatic t_tamper();
    logic [31:0] d; logic e;
    wr(ea(20), 32'hCAFE, 1, 0, e);
    @(negedge clk); tamper = 8'h04; @(negedge clk);
    rd(ea(20), 1, d, e); chk("R9 held at zero", d, 0);
    wr(ea(20), 32'h1, 1, 0, e); chk("R9 wr in hold no err", 32'(e), 0);
    @(negedge clk); tamper = 8'h00;
    rd(ea(20), 1, d, e); chk("R9 not restored", d, 0);
    wr(12'h004, 32'h0000_0400, 0, 0, e);
    wr(ea(20), 32'hBEEF, 1, 0, e);
    @(negedge clk); tamper = 8'h04; @(negedge clk);
    rd(ea(20), 1, d, e); chk("R9 noerase source keeps data", d, 32'hBEEF);
    @(negedge clk); tamper = 8'h05;
    rd(ea(20), 1, d, e); chk("R9 mixed sources erase", d, 0);
    @(negedge clk); tamper = 8'h00;
    rd(12'h004, 0, d, e); chk("R9 noerase mask readback", d, 32'h0000_0400);
  endtask

  task automatic t_block();
    logic [31:0] d; logic e;
    wr(12'h004, 32'h0000_0402, 0, 0, e);
    rd(ea(21), 1, d, e); chk("R10 sec rd blocked err", 32'(e), 1); chk("R10 data", d, 0);
    wr(ea(21), 32'h77, 1, 0, e); chk("R10 sec wr blocked", 32'(e), 1);
    rd(12'h004, 0, d, e); chk("R10 ctrl still readable", d, 32'h0000_0402);
    wr(12'h004, 32'h0, 0, 0, e);
    rd(ea(21), 1, d, e); chk("R10 blocked wr dropped", d, 0); chk("R10 unblocked err", 32'(e), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic e;
    rd(12'h008, 1, d, e); chk("R11 hole err", 32'(e), 1); chk("R11 hole data", d, 0);
    rd(12'h180, 1, d, e); chk("R11 past bank", 32'(e), 1);
    rd(12'h101, 1, d, e); chk("R11 unaligned", 32'(e), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_open();
    t_zones();
    t_degenerate();
    t_priv();
    t_erase();
    t_tamper();
    t_block();
    t_unmapped();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule